// File: doc/BRIEF.md
# DMA Protected Memory Range Unit

This block guards system memory against inbound DMA traffic during early boot. It holds two address windows. The low window lies below 4 GiB and is described by 32-bit base and limit registers. The optional high window spans the full host address width and is described by 64-bit registers. Firmware programs both windows through a 32-bit word-addressed register port and then sets an enable request. A status bit reports when protection is actually in force.

Each inbound DMA request presents its address on a dedicated input. The block answers in the same cycle with a block verdict. While the status bit is clear, every request is allowed. While it is set, a request is blocked if its address falls inside either window.

Base and limit registers implement only the bits above a fixed alignment granule, 1 MiB by default. Firmware discovers the granule by writing all ones to a limit register and negating the value it reads back. Version and capability words let firmware confirm that the unit is present and find out which windows exist. Once protection is in force, the window registers are frozen. Firmware therefore clears the enable request and waits for the status bit to drop before it reprograms or clears them.

Top module: `dma_prot_range_unit`

## Requirements
- R1: The word at offset 0x00 reads 0x00000010, with the major version 1 in bits 7:4 and the minor version 0 in bits 3:0. It never reads as all zeros or all ones.
- R2: The word at offset 0x08 has bit 5 set (low window present) and bit 6 equal to HAS_HIGH, which is 1 by default. All other bits of 0x08 read zero.
- R3: At offset 0x64, bit 31 is a read/write enable request and bit 0 is a read-only status. The status equals the value the enable request held two clock cycles earlier. All other bits read zero, and reset clears both bits.
- R4: The low base (0x68) and low limit (0x6C) keep only bits 31:20. Bits 19:0 always read zero, so writing 0xFFFFFFFF to 0x6C reads back 0xFFF00000.
- R5: The high base is reached as two 32-bit halves at 0x70 (bits 31:0) and 0x74 (bits 63:32). The high limit is reached the same way at 0x78 and 0x7C. Only bits 38:20 are stored. In particular, bits 31:7 of 0x74 and 0x7C read zero.
- R6: While the status bit is clear, dma_block_o is 0 for every address.
- R7: While the status bit is set, dma_block_o is 1 when the address, taken at 1 MiB granule resolution, lies between the base and the limit of either window, both ends inclusive. For the low window the address must also be below 4 GiB. The limit therefore covers its whole granule.
- R8: A window whose limit is below its base blocks no address.
- R9: While the status bit is set, writes to offsets 0x68 through 0x7C leave the stored values unchanged. Once the status bit is clear, such writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr_i | input | 8 | Byte offset of the register word; bits 1:0 are ignored |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| dma_addr_i | input | HAW (39) | Address of the inbound DMA request |
| dma_block_o | output | 1 | 1 when the request is blocked, combinational |

## Verification
A corrupted enable pipeline shows up at once in the 0x64 status bit. That bit must change exactly two edges after the request changes, and a verdict of block while status is clear is visible in the same cycle. A wrong window register is exposed by the read-back at its own offset: for example, low bits that are not hardwired, upper bits kept above the host width, or a write accepted while frozen. It is also exposed by the first address on either side of a granule boundary, where the verdict flips. Comparator errors, such as an exclusive limit or a low window that leaks above 4 GiB, appear on the very address that sits on the edge.

// File: rtl/dma_prot_pkg.sv
package dma_prot_pkg;

  // register word index = byte offset >> 2
  typedef enum logic [5:0] {
    W_VER      = 6'h00,
    W_CAP_LO   = 6'h02,
    W_CAP_HI   = 6'h03,
    W_PEN      = 6'h19,
    W_LBASE    = 6'h1A,
    W_LLIM     = 6'h1B,
    W_HBASE_LO = 6'h1C,
    W_HBASE_HI = 6'h1D,
    W_HLIM_LO  = 6'h1E,
    W_HLIM_HI  = 6'h1F
  } word_e;

  localparam int unsigned EN_REQ_BIT = 31;
  localparam int unsigned STATUS_BIT = 0;
  localparam int unsigned CAP_LO_BIT = 5;
  localparam int unsigned CAP_HI_BIT = 6;

endpackage

// File: rtl/dma_prot_en_pipe.sv
module dma_prot_en_pipe #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic status_o
);

  logic [LAT-1:0] pipe_q;

  if (LAT == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= en_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[LAT-2:0], en_i};
    end
  end

  assign status_o = pipe_q[LAT-1];

endmodule

// File: rtl/dma_prot_cmp.sv
module dma_prot_cmp #(
  parameter int unsigned IW = 19
) (
  input  logic [IW-1:0] addr_idx_i,
  input  logic [IW-1:0] base_i,
  input  logic [IW-1:0] lim_i,
  output logic          hit_o
);

  // inclusive on both ends; an inverted window matches nothing
  assign hit_o = (addr_idx_i >= base_i) && (addr_idx_i <= lim_i);

endmodule

// File: rtl/dma_prot_regs.sv
module dma_prot_regs
  import dma_prot_pkg::*;
#(
  parameter int unsigned HAW      = 39,
  parameter int unsigned GRAN     = 20,
  parameter bit          HAS_HIGH = 1'b1,
  parameter int unsigned VER_MAJ  = 1,
  parameter int unsigned VER_MIN  = 0,
  localparam int unsigned LO_W    = 32 - GRAN,
  localparam int unsigned IDX_W   = HAW - GRAN,
  localparam int unsigned UP_W    = HAW - 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  word_e            word_i,
  input  logic [31:0]      wdata_i,
  input  logic             status_i,
  output logic [31:0]      rdata_o,
  output logic             en_req_o,
  output logic [LO_W-1:0]  lo_base_o,
  output logic [LO_W-1:0]  lo_lim_o,
  output logic [IDX_W-1:0] hi_base_o,
  output logic [IDX_W-1:0] hi_lim_o
);

  logic            en_req_q;
  logic [LO_W-1:0] lo_base_q, lo_lim_q;
  logic            win_wr;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign win_wr = wr_i && !status_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_req_q  <= 1'b0;
      lo_base_q <= '0;
      lo_lim_q  <= '0;
    end else begin
      if (wr_i && word_i == W_PEN) en_req_q <= wdata_i[EN_REQ_BIT];
      if (win_wr && word_i == W_LBASE) lo_base_q <= wdata_i[31:GRAN];
      if (win_wr && word_i == W_LLIM)  lo_lim_q  <= wdata_i[31:GRAN];
    end
  end

  if (HAS_HIGH) begin : g_high
    logic [IDX_W-1:0] hb_q, hl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hb_q <= '0;
        hl_q <= '0;
      end else if (win_wr) begin
        if (word_i == W_HBASE_LO) hb_q[LO_W-1:0]     <= wdata_i[31:GRAN];
        if (word_i == W_HBASE_HI) hb_q[IDX_W-1:LO_W] <= wdata_i[UP_W-1:0];
        if (word_i == W_HLIM_LO)  hl_q[LO_W-1:0]     <= wdata_i[31:GRAN];
        if (word_i == W_HLIM_HI)  hl_q[IDX_W-1:LO_W] <= wdata_i[UP_W-1:0];
      end
    end
    assign hi_base_o = hb_q;
    assign hi_lim_o  = hl_q;
  end else begin : g_no_high
    assign hi_base_o = '0;
    assign hi_lim_o  = '0;
  end

  logic [63:0] hb_full, hl_full;
  assign hb_full = {{(64-HAW){1'b0}}, hi_base_o, {GRAN{1'b0}}};
  assign hl_full = {{(64-HAW){1'b0}}, hi_lim_o,  {GRAN{1'b0}}};

  always_comb begin
    rdata_o = '0;
    case (word_i)
      W_VER: begin
        rdata_o[7:4] = 4'(VER_MAJ);
        rdata_o[3:0] = 4'(VER_MIN);
      end
      W_CAP_LO: begin
        rdata_o[CAP_LO_BIT] = 1'b1;
        rdata_o[CAP_HI_BIT] = HAS_HIGH;
      end
      W_PEN: begin
        rdata_o[EN_REQ_BIT] = en_req_q;
        rdata_o[STATUS_BIT] = status_i;
      end
      W_LBASE:    rdata_o = {lo_base_q, {GRAN{1'b0}}};
      W_LLIM:     rdata_o = {lo_lim_q,  {GRAN{1'b0}}};
      W_HBASE_LO: rdata_o = hb_full[31:0];
      W_HBASE_HI: rdata_o = hb_full[63:32];
      W_HLIM_LO:  rdata_o = hl_full[31:0];
      W_HLIM_HI:  rdata_o = hl_full[63:32];
      default:    rdata_o = '0;
    endcase
  end

  assign en_req_o  = en_req_q;
  assign lo_base_o = lo_base_q;
  assign lo_lim_o  = lo_lim_q;

endmodule

// File: rtl/dma_prot_range_unit.sv
module dma_prot_range_unit
  import dma_prot_pkg::*;
#(
  parameter int unsigned HAW      = 39,
  parameter int unsigned GRAN     = 20,
  parameter bit          HAS_HIGH = 1'b1,
  parameter int unsigned EN_LAT   = 2,
  parameter int unsigned VER_MAJ  = 1,
  parameter int unsigned VER_MIN  = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_wr_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic [HAW-1:0] dma_addr_i,
  output logic           dma_block_o
);

  localparam int unsigned LO_W  = 32 - GRAN;
  localparam int unsigned IDX_W = HAW - GRAN;
  localparam int unsigned NR    = HAS_HIGH ? 2 : 1;

  logic             en_req, status;
  logic [LO_W-1:0]  lo_base, lo_lim;
  logic [IDX_W-1:0] hi_base, hi_lim;
  logic [IDX_W-1:0] addr_idx;
  logic [IDX_W-1:0] base_idx [NR];
  logic [IDX_W-1:0] lim_idx  [NR];
  logic [NR-1:0]    hit;
  logic             unused_in;

  assign unused_in = ^{reg_addr_i[1:0], dma_addr_i[GRAN-1:0]};

  dma_prot_regs #(
    .HAW(HAW), .GRAN(GRAN), .HAS_HIGH(HAS_HIGH),
    .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .word_i    (word_e'(reg_addr_i[7:2])),
    .wdata_i   (reg_wdata_i),
    .status_i  (status),
    .rdata_o   (reg_rdata_o),
    .en_req_o  (en_req),
    .lo_base_o (lo_base),
    .lo_lim_o  (lo_lim),
    .hi_base_o (hi_base),
    .hi_lim_o  (hi_lim)
  );

  dma_prot_en_pipe #(.LAT(EN_LAT)) i_en_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_req),
    .status_o (status)
  );

  assign addr_idx    = dma_addr_i[HAW-1:GRAN];
  // low window lives below 4 GiB: zero-extended registers enforce it
  assign base_idx[0] = IDX_W'(lo_base);
  assign lim_idx[0]  = IDX_W'(lo_lim);

  if (HAS_HIGH) begin : g_hi_win
    assign base_idx[NR-1] = hi_base;
    assign lim_idx[NR-1]  = hi_lim;
  end else begin : g_hi_off
    logic unused_hi;
    assign unused_hi = ^{hi_base, hi_lim};
  end

  for (genvar r = 0; r < NR; r++) begin : g_win
    dma_prot_cmp #(.IW(IDX_W)) i_cmp (
      .addr_idx_i (addr_idx),
      .base_i     (base_idx[r]),
      .lim_i      (lim_idx[r]),
      .hit_o      (hit[r])
    );
  end

  assign dma_block_o = status && (|hit);

endmodule

// File: rtl/dma_prot_chk.sv
module dma_prot_chk #(
  parameter int unsigned HAW  = 39,
  parameter int unsigned GRAN = 20,
  localparam int unsigned LO_W  = 32 - GRAN,
  localparam int unsigned IDX_W = HAW - GRAN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic             dma_block_o,
  input logic             en_req_i,
  input logic             status_i,
  input logic [LO_W-1:0]  lo_base_i,
  input logic [LO_W-1:0]  lo_lim_i,
  input logic [IDX_W-1:0] hi_base_i,
  input logic [IDX_W-1:0] hi_lim_i
);

  // R1
  ver_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 8'h00 |-> (reg_rdata_o != 32'h0 && reg_rdata_o != 32'hFFFF_FFFF));

  // R3
  status_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i == $past(en_req_i, 2));

  // R4
  lim_gran_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 8'h6C |-> reg_rdata_o[GRAN-1:0] == '0);

  // R5
  hi_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i[7:2] == 6'h1F |-> reg_rdata_o[31:HAW-32] == '0);

  // R6
  off_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i |-> !dma_block_o);

  // R9
  frozen_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i |=> $stable({lo_base_i, lo_lim_i, hi_base_i, hi_lim_i}));

endmodule

bind dma_prot_range_unit dma_prot_chk #(.HAW(HAW), .GRAN(GRAN)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .dma_block_o (dma_block_o),
  .en_req_i    (en_req),
  .status_i    (status),
  .lo_base_i   (lo_base),
  .lo_lim_i    (lo_lim),
  .hi_base_i   (hi_base),
  .hi_lim_i    (hi_lim)
);

// File: tb/test_dma_prot_range_unit.sv
module test_dma_prot_range_unit;

  localparam int unsigned HAW = 39;
  localparam int unsigned NV  = 10;

  // window setup for the table: low 0..0x3FFFFFFF, high 0x1_00000000..0x2_3FFFFFFF
  localparam logic [HAW-1:0] V_ADDR [NV] = '{
    39'h00_0000_0000, 39'h00_0FFF_FFFF, 39'h00_3FFF_FFFF, 39'h00_4000_0000,
    39'h00_FFFF_FFFF, 39'h01_0000_0000, 39'h01_8000_1234, 39'h02_3FFF_FFFF,
    39'h02_4000_0000, 39'h7F_FFFF_FFFF
  };
  localparam logic V_BLK [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [HAW-1:0] dma_addr = '0;
  logic           dma_block;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_prot_range_unit #(.HAW(HAW)) i_dma_prot_range_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .dma_addr_i  (dma_addr),
    .dma_block_o (dma_block)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic chk_dma(input string tag, input logic [HAW-1:0] a, input logic exp);
    dma_addr = a;
    #1;
    chk(tag, 64'(dma_block), 64'(exp));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // reset state
    chk_rd("R3 reset control", 8'h64, 32'h0000_0000);
    chk_dma("R6 reset allow", 39'h0, 1'b0);
    chk_rd("R1 version", 8'h00, 32'h0000_0010);
    chk_rd("R2 capability", 8'h08, 32'h0000_0060);
    chk_rd("R2 capability upper", 8'h0C, 32'h0);

    // granule discovery
    wr(8'h6C, 32'hFFFF_FFFF);
    chk_rd("R4 low limit mask", 8'h6C, 32'hFFF0_0000);
    chk("R4 granule", 64'(32'(~32'hFFF0_0000 + 32'd1)), 64'h0010_0000);
    wr(8'h68, 32'h1234_5678);
    chk_rd("R4 low base mask", 8'h68, 32'h1230_0000);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    chk_rd("R5 high limit lo half", 8'h78, 32'hFFF0_0000);
    chk_rd("R5 high limit hi half", 8'h7C, 32'h0000_007F);
    wr(8'h74, 32'hFFFF_FFFF);
    chk_rd("R5 high base hi half", 8'h74, 32'h0000_007F);

    // program windows
    wr(8'h68, 32'h0);
    wr(8'h6C, 32'h3FFF_FFFF);
    wr(8'h70, 32'h0);
    wr(8'h74, 32'h1);
    wr(8'h78, 32'h3FFF_FFFF);
    wr(8'h7C, 32'h2);
    chk_dma("R6 programmed but off", 39'h1000, 1'b0);

    // enable, status two edges later
    wr(8'h64, 32'h8000_0000);
    chk_rd("R3 status +0", 8'h64, 32'h8000_0000);
    chk_dma("R6 allow before status", 39'h1000, 1'b0);
    tick();
    chk_rd("R3 status +1", 8'h64, 32'h8000_0000);
    tick();
    chk_rd("R3 status +2", 8'h64, 32'h8000_0001);

    // verdict table
    for (int i = 0; i < NV; i++) begin
      chk_dma($sformatf("R7 vector %0d", i), V_ADDR[i], V_BLK[i]);
    end

    // frozen windows
    wr(8'h6C, 32'h0);
    wr(8'h7C, 32'h0);
    chk_rd("R9 low limit frozen", 8'h6C, 32'h3FF0_0000);
    chk_rd("R9 high limit frozen", 8'h7C, 32'h0000_0002);
    chk_dma("R9 still blocked", 39'h00_2000_0000, 1'b1);

    // disable, status drops two edges later
    wr(8'h64, 32'h0);
    chk_rd("R3 drop +0", 8'h64, 32'h0000_0001);
    tick();
    chk_rd("R3 drop +1", 8'h64, 32'h0000_0001);
    tick();
    chk_rd("R3 drop +2", 8'h64, 32'h0000_0000);
    chk_dma("R6 allow after disable", 39'h0, 1'b0);

    // writes accepted again; inverted low window
    wr(8'h6C, 32'h0);
    chk_rd("R9 write after drop", 8'h6C, 32'h0);
    wr(8'h68, 32'h2000_0000);
    wr(8'h64, 32'h8000_0000);
    tick();
    tick();
    chk_rd("R3 re-enable", 8'h64, 32'h8000_0001);
    chk_dma("R8 inverted inside", 39'h00_1000_0000, 1'b0);
    chk_dma("R8 inverted at base", 39'h00_2000_0000, 1'b0);
    chk_dma("R8 inverted at zero", 39'h0, 1'b0);
    chk_dma("R7 high still active", 39'h01_0000_0000, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule